// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Interrupt Wake-Up

This block sequences a processor core in and out of three reduced-power states (IDLE2, IDLE1, STOP) and the normal RUN state. The core raises a one-cycle halt request together with a mode code. The sequencer then runs an entry window of `ENTRY_CYC` clocks. During that window all clocks stay on. When the window ends, the block gates the core, peripheral, oscillator and real-time-counter clock enables according to the chosen mode.

Four request lines can end a halt: a non-maskable line, external line 0, the real-time-counter line and a general interrupt line. A request is the rising edge of its line. Each request sets a sticky pending flag, and every source has a level from 1 to 7. The non-maskable source always has level 7, and level 0 turns a source off. For IDLE1 and STOP, a request that arrives inside the entry window is only recorded and does not wake the core. A fresh request that arrives after the halt is complete releases it. Once the core is awake, the pending sources are handed out one at a time on a valid/take acknowledge port, highest level first.

Top module: `pwr_standby_ctrl`

## Requirements
- R1: After reset the block is in RUN. `cpu_clk_en`, `osc_en`, `rtc_clk_en` and every bit of `per_clk_en` are 1, and `ack_valid` is 0.
- R2: When `halt_req` is sampled high in RUN with `halt_mode` 1 (IDLE2), 2 (IDLE1) or 3 (STOP), an entry window of `ENTRY_CYC` cycles begins, and all enables stay as in RUN during it. With `halt_mode` 0 the request is ignored.
- R3: Once halted, the enables depend on the mode. IDLE2 gives `cpu_clk_en`=0, `per_clk_en`=`per_sel`, `osc_en`=1 and `rtc_clk_en`=1. IDLE1 gives `cpu_clk_en`=0, `per_clk_en`=0, `osc_en`=1 and `rtc_clk_en`=1. STOP drives all enables to 0.
- R4: A request is a 0-to-1 transition of its line. A source whose level is 0 is ignored: it sets no flag and wakes nothing. The non-maskable source has the fixed level 7.
- R5: In IDLE2, any enabled request releases the halt, including one inside the entry window. The block is back in RUN (`cpu_clk_en`=1) one cycle after the request is sampled.
- R6: In IDLE1 or STOP, a request that arrives inside the entry window is latched as pending and does not prevent or end the halt. A flag that is already pending never wakes the core by itself.
- R7: In a completed IDLE1 or STOP halt, a new request on the non-maskable, line-0 or real-time-counter input returns the block to RUN one cycle later. A general request is latched but does not wake.
- R8: `ack_valid` is 1 only in RUN while a flag is pending. `ack_src` is 0 for non-maskable, 1 for line 0, 2 for real-time counter and 3 for general. `ack_src`/`ack_lvl` present the pending source with the highest level, and on equal levels the lower code wins. The offer holds until `ack_take` is 1 in a cycle, and that flag then clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_req | input | 1 | One-cycle request to enter a low-power mode |
| halt_mode | input | 2 | Requested mode: 0 RUN, 1 IDLE2, 2 IDLE1, 3 STOP |
| irq_nmi | input | 1 | Non-maskable request line |
| irq_int0 | input | 1 | External request line 0 |
| irq_rtc | input | 1 | Real-time-counter request line |
| irq_gen | input | 1 | General interrupt request line |
| pri_int0 | input | 3 | Level of line 0 (0 = off) |
| pri_rtc | input | 3 | Level of real-time-counter line (0 = off) |
| pri_gen | input | 3 | Level of general line (0 = off) |
| per_sel | input | NPER | Peripherals kept clocked in IDLE2 |
| ack_take | input | 1 | Consumer accepts the offered source |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | NPER | Peripheral clock enables |
| osc_en | output | 1 | Oscillator enable |
| rtc_clk_en | output | 1 | Real-time-counter clock enable |
| ack_valid | output | 1 | A pending source is offered |
| ack_src | output | 2 | Offered source code |
| ack_lvl | output | 3 | Level of offered source |

## Verification
A request line pulsed between two falling edges is sampled at the single rising edge between them. Its flag, and any wake-up it causes, appears right after that edge. The monitor therefore sees the first offer at the very next falling edge, and each further pending source one cycle later. The halt request is sampled at an edge P0, and the enables change after edge P0+`ENTRY_CYC`. For that reason the enable checks wait `ENTRY_CYC`+3 falling edges. Window requests are placed right after the halt pulse, so they land on P1. Expected acknowledge order is pushed into a queue before each stimulus, and the monitor compares every accepted offer against the head of that queue.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE2 = 2'd1,
    MODE_IDLE1 = 2'd2,
    MODE_STOP  = 2'd3
  } pwr_mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_HALT  = 2'd2
  } seq_st_e;

  localparam int NSRC     = 4;
  localparam int SRCW     = $clog2(NSRC);
  localparam int LVLW     = 3;
  localparam int SRC_NMI  = 0;
  localparam int SRC_INT0 = 1;
  localparam int SRC_RTC  = 2;
  localparam int SRC_GEN  = 3;
  localparam logic [LVLW-1:0] NMI_LVL = '1;
  // sources that may end an IDLE1/STOP halt
  localparam logic [NSRC-1:0] DEEP_WAKE = 4'b0111;
endpackage

// File: rtl/psc_rst_sync.sv
module psc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sh_q[STAGES-1];
endmodule

// File: rtl/psc_seq.sv
module psc_seq import psc_pkg::*; #(
  parameter int ENTRY_CYC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req,
  input  pwr_mode_e       halt_mode,
  input  logic [NSRC-1:0] evt_ok,
  output seq_st_e         st,
  output pwr_mode_e       mode
);
  localparam int CW = $clog2(ENTRY_CYC + 1);

  seq_st_e   st_n;
  pwr_mode_e mode_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic      wake_idle2, wake_deep;

  assign wake_idle2 = |evt_ok;
  assign wake_deep  = |(evt_ok & DEEP_WAKE);

  always_comb begin
    st_n   = st;
    mode_n = mode;
    cnt_n  = cnt_q;
    case (st)
      ST_RUN: begin
        if (halt_req && (halt_mode != MODE_RUN)) begin
          st_n   = ST_ENTER;
          mode_n = halt_mode;
          cnt_n  = '0;
        end
      end
      ST_ENTER: begin
        if ((mode == MODE_IDLE2) && wake_idle2) begin
          st_n   = ST_RUN;
          mode_n = MODE_RUN;
        end else if (cnt_q == CW'(ENTRY_CYC - 1)) begin
          st_n = ST_HALT;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_HALT: begin
        if ((mode == MODE_IDLE2) ? wake_idle2 : wake_deep) begin
          st_n   = ST_RUN;
          mode_n = MODE_RUN;
        end
      end
      default: begin
        st_n   = ST_RUN;
        mode_n = MODE_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_RUN;
      mode  <= MODE_RUN;
      cnt_q <= '0;
    end else begin
      st    <= st_n;
      mode  <= mode_n;
      cnt_q <= cnt_n;
    end
  end

  // R2
  entry_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && halt_req && halt_mode != MODE_RUN) |=> (st == ST_ENTER));

  // R6
  entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ENTER && (mode == MODE_IDLE1 || mode == MODE_STOP)) |=> (st != ST_RUN));

  // R7
  halt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALT && (|(evt_ok & DEEP_WAKE))) |=> (st == ST_RUN));
endmodule

// File: rtl/psc_pend.sv
module psc_pend import psc_pkg::*; (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           evt_ok,
  input  logic [NSRC-1:0][LVLW-1:0] lvl,
  input  logic                      awake,
  input  logic                      ack_take,
  output logic                      ack_valid,
  output logic [SRCW-1:0]           ack_src,
  output logic [LVLW-1:0]           ack_lvl
);
  logic [NSRC-1:0] flag_q, flag_n, clr;
  logic [SRCW-1:0] best;
  logic [LVLW-1:0] best_lvl;
  logic            found;

  always_comb begin
    best     = '0;
    best_lvl = '0;
    found    = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (flag_q[i] && (!found || lvl[i] > best_lvl)) begin
        best     = SRCW'(i);
        best_lvl = lvl[i];
        found    = 1'b1;
      end
    end
  end

  assign ack_valid = awake && found;
  assign ack_src   = best;
  assign ack_lvl   = best_lvl;

  always_comb begin
    clr = '0;
    if (ack_valid && ack_take) clr[best] = 1'b1;
    flag_n = (flag_q & ~clr) | evt_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_n;
  end

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_ok) |=> ((flag_q & $past(evt_ok)) == $past(evt_ok)));

  // R8
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_take && !evt_ok[ack_src]) |=> !flag_q[$past(ack_src)]);
endmodule

// File: rtl/psc_clkgate.sv
module psc_clkgate import psc_pkg::*; #(
  parameter int NPER = 4
) (
  input  seq_st_e         st,
  input  pwr_mode_e       mode,
  input  logic [NPER-1:0] per_sel,
  output logic            cpu_en,
  output logic [NPER-1:0] per_en,
  output logic            osc_en,
  output logic            rtc_en
);
  logic halted;
  assign halted = (st == ST_HALT);

  assign cpu_en = !halted;
  assign osc_en = !(halted && mode == MODE_STOP);
  assign rtc_en = osc_en;

  for (genvar g = 0; g < NPER; g++) begin : g_per
    assign per_en[g] = !halted || (mode == MODE_IDLE2 && per_sel[g]);
  end
endmodule

// File: rtl/pwr_standby_ctrl.sv
module pwr_standby_ctrl import psc_pkg::*; #(
  parameter int ENTRY_CYC = 5,
  parameter int NPER      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req,
  input  logic [1:0]      halt_mode,
  input  logic            irq_nmi,
  input  logic            irq_int0,
  input  logic            irq_rtc,
  input  logic            irq_gen,
  input  logic [LVLW-1:0] pri_int0,
  input  logic [LVLW-1:0] pri_rtc,
  input  logic [LVLW-1:0] pri_gen,
  input  logic [NPER-1:0] per_sel,
  input  logic            ack_take,
  output logic            cpu_clk_en,
  output logic [NPER-1:0] per_clk_en,
  output logic            osc_en,
  output logic            rtc_clk_en,
  output logic            ack_valid,
  output logic [SRCW-1:0] ack_src,
  output logic [LVLW-1:0] ack_lvl
);
  logic                      rst_s_n;
  logic [NSRC-1:0]           req, req_q, evt_ok;
  logic [NSRC-1:0][LVLW-1:0] lvl;
  seq_st_e                   st;
  pwr_mode_e                 mode;

  psc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  assign req = {irq_gen, irq_rtc, irq_int0, irq_nmi};
  assign lvl = {pri_gen, pri_rtc, pri_int0, NMI_LVL};

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) req_q <= '0;
    else          req_q <= req;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_evt
    assign evt_ok[g] = req[g] && !req_q[g] && (lvl[g] != '0);
  end

  psc_seq #(.ENTRY_CYC(ENTRY_CYC)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .halt_req(halt_req),
    .halt_mode(pwr_mode_e'(halt_mode)), .evt_ok(evt_ok),
    .st(st), .mode(mode)
  );

  psc_pend u_pend (
    .clk(clk), .rst_n(rst_s_n), .evt_ok(evt_ok), .lvl(lvl),
    .awake(st == ST_RUN), .ack_take(ack_take),
    .ack_valid(ack_valid), .ack_src(ack_src), .ack_lvl(ack_lvl)
  );

  psc_clkgate #(.NPER(NPER)) u_gate (
    .st(st), .mode(mode), .per_sel(per_sel),
    .cpu_en(cpu_clk_en), .per_en(per_clk_en),
    .osc_en(osc_en), .rtc_en(rtc_clk_en)
  );

  // R8
  ack_awake_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ack_valid |-> cpu_clk_en);

  // R4
  off_src_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pri_rtc == '0 && st == ST_HALT && mode != MODE_IDLE2 && !(|(evt_ok & 4'b0011)))
      |=> !cpu_clk_en);
endmodule

// File: tb/pwr_standby_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_standby_ctrl_bench;
  localparam int ENTRY = 5;
  localparam int NPER  = 4;

  logic clk = 1'b0;
  logic rst_n, halt_req, irq_nmi, irq_int0, irq_rtc, irq_gen, ack_take;
  logic [1:0] halt_mode;
  logic [2:0] pri_int0, pri_rtc, pri_gen;
  logic [NPER-1:0] per_sel, per_clk_en;
  logic cpu_clk_en, osc_en, rtc_clk_en, ack_valid;
  logic [1:0] ack_src;
  logic [2:0] ack_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [4:0] exp_q[$];

  always #2.5 clk = ~clk;

  pwr_standby_ctrl #(.ENTRY_CYC(ENTRY), .NPER(NPER)) u_pwr_standby_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_mode(halt_mode),
    .irq_nmi(irq_nmi), .irq_int0(irq_int0), .irq_rtc(irq_rtc), .irq_gen(irq_gen),
    .pri_int0(pri_int0), .pri_rtc(pri_rtc), .pri_gen(pri_gen), .per_sel(per_sel),
    .ack_take(ack_take), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .rtc_clk_en(rtc_clk_en), .ack_valid(ack_valid),
    .ack_src(ack_src), .ack_lvl(ack_lvl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ack(input logic [1:0] s, input logic [2:0] l);
    exp_q.push_back({s, l});
  endtask

  // monitor: every accepted offer must match the queue head
  always @(negedge clk) begin
    if (rst_n && ack_valid && ack_take) begin
      if (exp_q.size() == 0) chk("R8 unexpected offer", {27'd0, ack_src, ack_lvl}, 32'h1f);
      else                   chk("R8 offer order", {27'd0, ack_src, ack_lvl}, {27'd0, exp_q.pop_front()});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic halt(input logic [1:0] m);
    @(negedge clk); halt_req = 1'b1; halt_mode = m;
    @(negedge clk); halt_req = 1'b0;
  endtask

  // bits {gen, rtc, int0, nmi}
  task automatic pulse(input logic [3:0] b);
    irq_nmi = b[0]; irq_int0 = b[1]; irq_rtc = b[2]; irq_gen = b[3];
    @(negedge clk);
    irq_nmi = 0; irq_int0 = 0; irq_rtc = 0; irq_gen = 0;
  endtask

  task automatic drained(input string tag);
    idle(3);
    chk(tag, exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; halt_req = 0; halt_mode = 0; ack_take = 1;
    irq_nmi = 0; irq_int0 = 0; irq_rtc = 0; irq_gen = 0;
    pri_int0 = 3; pri_rtc = 5; pri_gen = 2; per_sel = 4'b0101;
    idle(3); rst_n = 1; idle(4);

    // R1 reset state
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 per_clk_en", per_clk_en, 4'hf);
    chk("R1 osc/rtc", {osc_en, rtc_clk_en}, 2'b11);
    chk("R1 ack_valid", ack_valid, 0);

    // R8 single request while running
    expect_ack(1, 3);
    @(negedge clk); pulse(4'b0010);
    drained("R8 line0 served");

    // R8 two requests together, higher level first
    expect_ack(2, 5); expect_ack(3, 2);
    @(negedge clk); pulse(4'b1100);
    drained("R8 rtc then gen");

    // R8 tie on level: lower code first
    pri_gen = 5;
    expect_ack(2, 5); expect_ack(3, 5);
    @(negedge clk); pulse(4'b1100);
    drained("R8 tie order");
    pri_gen = 2;

    // R2 mode 0 request ignored
    halt(2'd0); idle(ENTRY + 3);
    chk("R2 run-mode halt ignored", cpu_clk_en, 1);

    // R2 enables stay on through the window
    halt(2'd2); idle(2);
    chk("R2 clocks on in window", {cpu_clk_en, per_clk_en}, 5'h1f);
    idle(ENTRY + 1);
    // R3 IDLE1 gating
    chk("R3 idle1 cpu", cpu_clk_en, 0);
    chk("R3 idle1 per", per_clk_en, 0);
    chk("R3 idle1 osc/rtc", {osc_en, rtc_clk_en}, 2'b11);
    // R7 general request latched, no wake
    pulse(4'b1000); idle(3);
    chk("R7 gen does not wake", cpu_clk_en, 0);
    chk("R8 no offer while halted", ack_valid, 0);
    expect_ack(0, 7); expect_ack(3, 2);
    pulse(4'b0001);
    chk("R7 nmi wakes idle1", cpu_clk_en, 1);
    drained("R7 nmi then gen");

    // R3 IDLE2 gating, R5 wake
    halt(2'd1); idle(ENTRY + 3);
    chk("R3 idle2 cpu", cpu_clk_en, 0);
    chk("R3 idle2 per", per_clk_en, per_sel);
    chk("R3 idle2 osc/rtc", {osc_en, rtc_clk_en}, 2'b11);
    expect_ack(3, 2);
    pulse(4'b1000);
    chk("R5 gen wakes idle2", cpu_clk_en, 1);
    drained("R5 gen served");

    // R5 request inside the IDLE2 window aborts entry
    expect_ack(1, 3);
    halt(2'd1); pulse(4'b0010);
    idle(ENTRY + 3);
    chk("R5 window request releases idle2", cpu_clk_en, 1);
    drained("R5 line0 served");

    // R6 request in STOP window is held; R3 STOP gating
    pri_rtc = 6; pri_int0 = 1;
    halt(2'd3); pulse(4'b0100);
    idle(ENTRY + 3);
    chk("R6 stop entered despite rtc", cpu_clk_en, 0);
    chk("R3 stop all off", {per_clk_en, osc_en, rtc_clk_en}, 0);
    idle(6);
    chk("R6 pending flag no wake", cpu_clk_en, 0);
    chk("R6 no offer while halted", ack_valid, 0);
    expect_ack(2, 6); expect_ack(1, 1);
    pulse(4'b0010);
    chk("R7 line0 wakes stop", cpu_clk_en, 1);
    drained("R6 held rtc served first");

    // R6 held nmi in IDLE1, later line0 wakes: nmi first
    halt(2'd2); idle(1); pulse(4'b0001);
    idle(ENTRY + 2);
    chk("R6 idle1 entered despite nmi", cpu_clk_en, 0);
    expect_ack(0, 7); expect_ack(1, 1);
    pulse(4'b0010);
    drained("R6 nmi then line0");

    // R4 level 0 source ignored
    pri_rtc = 0;
    halt(2'd2); idle(ENTRY + 3);
    pulse(4'b0100); idle(3);
    chk("R4 disabled rtc no wake", cpu_clk_en, 0);
    expect_ack(0, 7);
    pulse(4'b0001);
    drained("R4 disabled rtc no flag");
    pri_rtc = 5;

    // R8 offer held without take
    ack_take = 0;
    pulse(4'b0010); idle(3);
    chk("R8 offer held valid", ack_valid, 1);
    chk("R8 offer held src", {ack_src, ack_lvl}, {2'd1, 3'd1});
    expect_ack(1, 1);
    ack_take = 1;
    drained("R8 held offer taken");
    chk("R8 flag cleared", ack_valid, 0);

    finish_run();
  end
endmodule